// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block decides, every cycle, whether the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) may advance, and where each of its two source operands should come from. It looks at the two source register numbers of the instruction in decode and at the destination register, valid bit, write flag and load flag of the instructions in execute, memory and writeback. From these it produces a combined stall for fetch and decode, a bubble into execute, annul strobes for the two youngest stages, and a 2-bit bypass select per operand.

Fetch always guesses the next sequential instruction. Branches and jumps resolve in execute, and a redirect there annuls the instructions in fetch and decode. Load data only becomes available in writeback, so a dependent instruction waits while the load sits in execute and then in memory. That costs two bubbles. A build-time parameter removes the execute-stage bypass. A dependency on the instruction directly ahead then also waits one cycle and takes its value from the memory stage.

The block is purely combinational. The clock and active-low reset only time its internal checks.

Top module: `hazardUnit`

## Requirements
- R1: A source register number of 0 never creates a dependency: its bypass select is 00 and it never causes a stall, even when a producer writes register 0.
- R2: The bypass select codes are 00 register file, 01 execute, 10 memory and 11 writeback. The youngest matching producer wins, in the order execute, memory, writeback. A slot with its valid bit low or its write flag low is never a producer.
- R3: With the execute bypass enabled, a dependency on an ALU result in execute, memory or writeback causes no stall. The select names the stage that holds the result.
- R4: When decode is valid and a source matches a load in execute or in memory (and no younger producer matches), stallIf, stallDec and bubbleExe are all 1. A matching load in writeback causes no stall and selects 11.
- R5: With the execute bypass disabled (EXE_BYPASS=0), a dependency on a non-load producer in execute stalls decode and never selects 01. Once that producer reaches memory, the select is 10 with no stall.
- R6: When execute signals a redirect, annulIf and annulDec are 1. The redirect overrides any stall: stallIf, stallDec and bubbleExe are 0 that cycle.
- R7: A source whose youngest matching producer is a load in execute or memory selects 00. A load in those stages is never a bypass source, but a younger matching ALU producer in execute is still selected.
- R8: When decode holds no valid instruction, no stall is raised, whatever the producers hold.
- R9: stallIf, stallDec and bubbleExe always carry the same value. annulIf and annulDec are 0 when there is no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that times the internal checks |
| rstN | input | 1 | Active-low reset; the checks are off while it is low |
| decValid | input | 1 | Decode holds a valid instruction |
| decRs1 | input | RW | First source register of the decode instruction |
| decRs2 | input | RW | Second source register of the decode instruction |
| exeValid | input | 1 | Execute slot holds a live instruction |
| exeRd | input | RW | Destination register in execute |
| exeWr | input | 1 | Execute instruction writes a register |
| exeLoad | input | 1 | Execute instruction is a load |
| memValid | input | 1 | Memory slot holds a live instruction |
| memRd | input | RW | Destination register in memory |
| memWr | input | 1 | Memory instruction writes a register |
| memLoad | input | 1 | Memory instruction is a load |
| wbValid | input | 1 | Writeback slot holds a live instruction |
| wbRd | input | RW | Destination register in writeback |
| wbWr | input | 1 | Writeback instruction writes a register |
| exeRedirect | input | 1 | Taken branch or jump resolved in execute |
| stallIf | output | 1 | Hold the fetch stage |
| stallDec | output | 1 | Hold the decode stage |
| bubbleExe | output | 1 | Insert a bubble into execute |
| annulIf | output | 1 | Annul the instruction in fetch |
| annulDec | output | 1 | Annul the instruction in decode |
| fwdSel1 | output | 2 | Bypass select for the first operand |
| fwdSel2 | output | 2 | Bypass select for the second operand |

## Verification
On every clock edge the assertions check four relations. Register 0 always selects the register file. An unavailable load is never picked as a source. With the execute bypass removed, 01 is never produced. A redirect always annuls and overrides any stall. They also check that an invalid decode never stalls, and that a matching load in execute always stalls. The bench scenarios cover the rest. They show the full priority order among three matching producers and that invalid or non-writing slots are ignored. They show the two-step wait of a load-use as the load moves from execute to memory to writeback. They also show the one-cycle wait, followed by a memory-stage bypass, in the build without the execute bypass.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_EXE = 2'b01,
    SRC_MEM = 2'b10,
    SRC_WB  = 2'b11
  } fwdSrcE;

  typedef struct packed {
    logic stallIf;
    logic stallDec;
    logic bubbleExe;
    logic annulIf;
    logic annulDec;
  } ctrlStrobesT;
endpackage

// File: rtl/hzOperandMatch.sv
module hzOperandMatch
  import hz_pkg::*;
#(
  parameter int RW = 5,
  parameter bit EXE_BYPASS = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [RW-1:0] srcReg,
  input  logic          exeValid,
  input  logic [RW-1:0] exeRd,
  input  logic          exeWr,
  input  logic          exeLoad,
  input  logic          memValid,
  input  logic [RW-1:0] memRd,
  input  logic          memWr,
  input  logic          memLoad,
  input  logic          wbValid,
  input  logic [RW-1:0] wbRd,
  input  logic          wbWr,
  output fwdSrcE        fwdSel,
  output logic          waitHit
);
  logic srcLive, exeHit, memHit, wbHit;

  assign srcLive = (srcReg != '0);
  assign exeHit  = srcLive && exeValid && exeWr && (exeRd == srcReg);
  assign memHit  = srcLive && memValid && memWr && (memRd == srcReg);
  assign wbHit   = srcLive && wbValid  && wbWr  && (wbRd  == srcReg);

  always_comb begin
    fwdSel  = SRC_RF;
    waitHit = 1'b0;
    if (exeHit) begin
      if (exeLoad || !EXE_BYPASS) waitHit = 1'b1;
      else                        fwdSel  = SRC_EXE;
    end else if (memHit) begin
      if (memLoad) waitHit = 1'b1;
      else         fwdSel  = SRC_MEM;
    end else if (wbHit) begin
      fwdSel = SRC_WB;
    end
  end

  // R1
  x0_src_rf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcReg == '0) |-> (fwdSel == SRC_RF && !waitHit));

  // R7
  no_exe_load_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fwdSel == SRC_EXE) |-> !exeLoad);

  // R7
  no_mem_load_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fwdSel == SRC_MEM) |-> !memLoad);

  generate
    if (!EXE_BYPASS) begin : g_noExe
      // R5
      no_exe_path_chk: assert property (@(posedge clk) disable iff (!rstN)
        fwdSel != SRC_EXE);
    end
  endgenerate
endmodule

// File: rtl/hzBypassPath.sv
module hzBypassPath
  import hz_pkg::*;
#(
  parameter int RW = 5,
  parameter int NSRC = 2,
  parameter bit EXE_BYPASS = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [RW-1:0] srcRegs [NSRC],
  input  logic          exeValid,
  input  logic [RW-1:0] exeRd,
  input  logic          exeWr,
  input  logic          exeLoad,
  input  logic          memValid,
  input  logic [RW-1:0] memRd,
  input  logic          memWr,
  input  logic          memLoad,
  input  logic          wbValid,
  input  logic [RW-1:0] wbRd,
  input  logic          wbWr,
  output fwdSrcE        fwdSels [NSRC],
  output logic [NSRC-1:0] waitVec
);
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      hzOperandMatch #(.RW(RW), .EXE_BYPASS(EXE_BYPASS)) uMatch (
        .clk(clk), .rstN(rstN), .srcReg(srcRegs[i]),
        .exeValid(exeValid), .exeRd(exeRd), .exeWr(exeWr), .exeLoad(exeLoad),
        .memValid(memValid), .memRd(memRd), .memWr(memWr), .memLoad(memLoad),
        .wbValid(wbValid), .wbRd(wbRd), .wbWr(wbWr),
        .fwdSel(fwdSels[i]), .waitHit(waitVec[i])
      );
    end
  endgenerate
endmodule

// File: rtl/hzStallCtrl.sv
module hzStallCtrl
  import hz_pkg::*;
#(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            decValid,
  input  logic [NSRC-1:0] waitVec,
  input  logic            exeRedirect,
  output ctrlStrobesT     strobes
);
  logic holdDec;

  assign holdDec = decValid && (|waitVec) && !exeRedirect;

  always_comb begin
    strobes.stallIf   = holdDec;
    strobes.stallDec  = holdDec;
    strobes.bubbleExe = holdDec;
    strobes.annulIf   = exeRedirect;
    strobes.annulDec  = exeRedirect;
  end

  // R6
  redirect_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    exeRedirect |-> (strobes.annulIf && strobes.annulDec && !strobes.stallDec && !strobes.bubbleExe));

  // R8
  idle_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> (!strobes.stallIf && !strobes.stallDec));

  // R9
  no_spurious_annul_chk: assert property (@(posedge clk) disable iff (!rstN)
    !exeRedirect |-> (!strobes.annulIf && !strobes.annulDec));
endmodule

// File: rtl/hazardUnit.sv
module hazardUnit
  import hz_pkg::*;
#(
  parameter int RW = 5,
  parameter bit EXE_BYPASS = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          decValid,
  input  logic [RW-1:0] decRs1,
  input  logic [RW-1:0] decRs2,
  input  logic          exeValid,
  input  logic [RW-1:0] exeRd,
  input  logic          exeWr,
  input  logic          exeLoad,
  input  logic          memValid,
  input  logic [RW-1:0] memRd,
  input  logic          memWr,
  input  logic          memLoad,
  input  logic          wbValid,
  input  logic [RW-1:0] wbRd,
  input  logic          wbWr,
  input  logic          exeRedirect,
  output logic          stallIf,
  output logic          stallDec,
  output logic          bubbleExe,
  output logic          annulIf,
  output logic          annulDec,
  output logic [1:0]    fwdSel1,
  output logic [1:0]    fwdSel2
);
  localparam int NSRC = 2;

  logic [RW-1:0]   srcRegs [NSRC];
  fwdSrcE          fwdSels [NSRC];
  logic [NSRC-1:0] waitVec;
  ctrlStrobesT     strobes;

  assign srcRegs[0] = decRs1;
  assign srcRegs[1] = decRs2;

  hzBypassPath #(.RW(RW), .NSRC(NSRC), .EXE_BYPASS(EXE_BYPASS)) uPath (
    .clk(clk), .rstN(rstN), .srcRegs(srcRegs),
    .exeValid(exeValid), .exeRd(exeRd), .exeWr(exeWr), .exeLoad(exeLoad),
    .memValid(memValid), .memRd(memRd), .memWr(memWr), .memLoad(memLoad),
    .wbValid(wbValid), .wbRd(wbRd), .wbWr(wbWr),
    .fwdSels(fwdSels), .waitVec(waitVec)
  );

  hzStallCtrl #(.NSRC(NSRC)) uCtrl (
    .clk(clk), .rstN(rstN), .decValid(decValid), .waitVec(waitVec),
    .exeRedirect(exeRedirect), .strobes(strobes)
  );

  assign stallIf   = strobes.stallIf;
  assign stallDec  = strobes.stallDec;
  assign bubbleExe = strobes.bubbleExe;
  assign annulIf   = strobes.annulIf;
  assign annulDec  = strobes.annulDec;
  assign fwdSel1   = fwdSels[0];
  assign fwdSel2   = fwdSels[1];

  // R4
  load_use_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !exeRedirect && exeValid && exeWr && exeLoad &&
     decRs1 != '0 && exeRd == decRs1) |-> (stallDec && stallIf && bubbleExe));
endmodule

// File: tb/tb_hazardUnit.sv
module tb_hazardUnit;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic decValid, exeValid, exeWr, exeLoad, memValid, memWr, memLoad, wbValid, wbWr, exeRedirect;
  logic [RW-1:0] decRs1, decRs2, exeRd, memRd, wbRd;
  logic stallIf, stallDec, bubbleExe, annulIf, annulDec;
  logic [1:0] fwdSel1, fwdSel2;
  logic nStallIf, nStallDec, nBubble, nAnnulIf, nAnnulDec;
  logic [1:0] nFwd1, nFwd2;

  hazardUnit #(.RW(RW), .EXE_BYPASS(1'b1)) dut (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decRs1(decRs1), .decRs2(decRs2),
    .exeValid(exeValid), .exeRd(exeRd), .exeWr(exeWr), .exeLoad(exeLoad),
    .memValid(memValid), .memRd(memRd), .memWr(memWr), .memLoad(memLoad),
    .wbValid(wbValid), .wbRd(wbRd), .wbWr(wbWr), .exeRedirect(exeRedirect),
    .stallIf(stallIf), .stallDec(stallDec), .bubbleExe(bubbleExe),
    .annulIf(annulIf), .annulDec(annulDec), .fwdSel1(fwdSel1), .fwdSel2(fwdSel2));

  hazardUnit #(.RW(RW), .EXE_BYPASS(1'b0)) dutNb (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decRs1(decRs1), .decRs2(decRs2),
    .exeValid(exeValid), .exeRd(exeRd), .exeWr(exeWr), .exeLoad(exeLoad),
    .memValid(memValid), .memRd(memRd), .memWr(memWr), .memLoad(memLoad),
    .wbValid(wbValid), .wbRd(wbRd), .wbWr(wbWr), .exeRedirect(exeRedirect),
    .stallIf(nStallIf), .stallDec(nStallDec), .bubbleExe(nBubble),
    .annulIf(nAnnulIf), .annulDec(nAnnulDec), .fwdSel1(nFwd1), .fwdSel2(nFwd2));

  typedef struct packed {
    logic dv; logic [4:0] r1; logic [4:0] r2;
    logic ev; logic [4:0] erd; logic ew; logic el;
    logic mv; logic [4:0] mrd; logic mw; logic ml;
    logic wv; logic [4:0] wrd; logic ww;
    logic rdr;
    logic xs; logic xa; logic [1:0] xf1; logic [1:0] xf2;
    logic [3:0] req;
  } vecT;

  localparam int NV = 14;
  localparam vecT TBL [NV] = '{
    '{1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 4'd8}, // R8 idle
    '{1'b1, 5'd0, 5'd3, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3, 4'd1}, // R1
    '{1'b1, 5'd5, 5'd6, 1'b1, 5'd5, 1'b1, 1'b0, 1'b1, 5'd5, 1'b1, 1'b0, 1'b1, 5'd6, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 2'd3, 4'd2}, // R2
    '{1'b1, 5'd7, 5'd7, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'd7, 1'b1, 1'b0, 1'b1, 5'd7, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd2, 4'd2}, // R2
    '{1'b1, 5'd7, 5'd7, 1'b0, 5'd7, 1'b1, 1'b0, 1'b1, 5'd7, 1'b0, 1'b0, 1'b1, 5'd7, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 2'd3, 4'd2}, // R2 ignored slots
    '{1'b1, 5'd8, 5'd1, 1'b1, 5'd8, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 4'd4}, // R4 load in EXE
    '{1'b1, 5'd2, 5'd8, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'd8, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 4'd4}, // R4 load in MEM
    '{1'b1, 5'd8, 5'd2, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'd8, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0, 4'd4}, // R4 load in WB
    '{1'b1, 5'd9, 5'd9, 1'b1, 5'd9, 1'b1, 1'b0, 1'b1, 5'd9, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd1, 4'd7}, // R7 younger ALU wins
    '{1'b1, 5'd9, 5'd0, 1'b1, 5'd9, 1'b1, 1'b1, 1'b1, 5'd9, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 4'd7}, // R7 load shadows MEM
    '{1'b0, 5'd8, 5'd0, 1'b1, 5'd8, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 4'd8}, // R8
    '{1'b1, 5'd8, 5'd0, 1'b1, 5'd8, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 4'd6}, // R6
    '{1'b1, 5'd4, 5'd4, 1'b1, 5'd4, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd1, 4'd3}, // R3
    '{1'b1, 5'd4, 5'd5, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'd4, 1'b1, 1'b0, 1'b1, 5'd5, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd3, 4'd3}  // R3
  };

  int total = 0;
  int bad = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input vecT v);
    decValid = v.dv; decRs1 = v.r1; decRs2 = v.r2;
    exeValid = v.ev; exeRd = v.erd; exeWr = v.ew; exeLoad = v.el;
    memValid = v.mv; memRd = v.mrd; memWr = v.mw; memLoad = v.ml;
    wbValid = v.wv; wbRd = v.wrd; wbWr = v.ww; exeRedirect = v.rdr;
  endtask

  initial begin
    drive('0);
    repeat (2) @(posedge clk);
    // reset state, R9
    @(negedge clk); #1;
    chk({stallIf, stallDec, bubbleExe, annulIf, annulDec} == 5'b0, "R9 reset", {stallIf, stallDec, bubbleExe, annulIf, annulDec}, 0);
    chk(fwdSel1 == 2'd0 && fwdSel2 == 2'd0, "R2 reset", {fwdSel1, fwdSel2}, 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      #2;
      chk(stallIf == TBL[i].xs && stallDec == TBL[i].xs && bubbleExe == TBL[i].xs,
          $sformatf("R%0d/R9 stall v%0d", TBL[i].req, i), {stallIf, stallDec, bubbleExe}, {3{TBL[i].xs}});
      chk(annulIf == TBL[i].xa && annulDec == TBL[i].xa,
          $sformatf("R%0d/R9 annul v%0d", TBL[i].req, i), {annulIf, annulDec}, {2{TBL[i].xa}});
      chk(fwdSel1 == TBL[i].xf1, $sformatf("R%0d fwd1 v%0d", TBL[i].req, i), fwdSel1, TBL[i].xf1);
      chk(fwdSel2 == TBL[i].xf2, $sformatf("R%0d fwd2 v%0d", TBL[i].req, i), fwdSel2, TBL[i].xf2);
    end

    // R5: no execute bypass, ALU producer directly ahead
    @(negedge clk);
    drive('0);
    decValid = 1'b1; decRs1 = 5'd4; exeValid = 1'b1; exeRd = 5'd4; exeWr = 1'b1;
    #2;
    chk(nStallDec && nStallIf && nBubble, "R5 stall on EXE producer", nStallDec, 1);
    chk(nFwd1 == 2'd0, "R5 no EXE select", nFwd1, 0);
    chk(!stallDec && fwdSel1 == 2'd1, "R3 full bypass same case", fwdSel1, 1);
    // producer advances to MEM
    @(negedge clk);
    exeValid = 1'b0; memValid = 1'b1; memRd = 5'd4; memWr = 1'b1;
    #2;
    chk(!nStallDec && nFwd1 == 2'd2, "R5 MEM select after wait", nFwd1, 2);

    // R4: load-use sequence, two stalled cycles then writeback bypass
    @(negedge clk);
    drive('0);
    decValid = 1'b1; decRs2 = 5'd12; exeValid = 1'b1; exeRd = 5'd12; exeWr = 1'b1; exeLoad = 1'b1;
    #2;
    chk(stallDec && nStallDec, "R4 seq cycle1", stallDec, 1);
    @(negedge clk);
    exeValid = 1'b0; memValid = 1'b1; memRd = 5'd12; memWr = 1'b1; memLoad = 1'b1;
    #2;
    chk(stallDec && nStallDec && fwdSel2 == 2'd0, "R4 seq cycle2", stallDec, 1);
    @(negedge clk);
    memValid = 1'b0; wbValid = 1'b1; wbRd = 5'd12; wbWr = 1'b1;
    #2;
    chk(!stallDec && fwdSel2 == 2'd3 && nFwd2 == 2'd3, "R4 seq cycle3", fwdSel2, 3);

    // R6 on the no-bypass build with its stall pending
    @(negedge clk);
    drive('0);
    decValid = 1'b1; decRs1 = 5'd6; exeValid = 1'b1; exeRd = 5'd6; exeWr = 1'b1; exeRedirect = 1'b1;
    #2;
    chk(!nStallDec && nAnnulIf && nAnnulDec, "R6 override no-bypass", nStallDec, 0);

    @(negedge clk);
    drive('0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule